// File: doc/BRIEF.md
# MSI capability and interrupt dispatcher

This block keeps the message-signalled-interrupt capability state of a PCI-style function and decides how each power-management event notification reaches the host. When message interrupts are switched on, an event becomes a 32-bit memory write. The write goes to the programmed, DWord-aligned address and carries the programmed 16-bit message value, zero-extended. When message interrupts are switched off, the event instead sets a legacy interrupt status flag. That flag drives the wired INTA level until software clears it.

Configuration software reaches the registers through a DWord-addressed port with per-byte enables. Reads are combinational on the offset. The capability dword sits at parameter `CAP_OFS` (default 90h), and its message control word occupies the upper half (bytes 92h–93h). The address dword follows at 94h and the message data at 98h. The legacy status flag lives in the dword at `STS_OFS` (default 04h), bit 19, which is bit 3 of byte 06h. The memory-write request uses a valid/ready handshake. A single pending slot covers events that arrive while a write waits for acceptance.

Top module: `msi_irq_dispatch`

## Requirements
- R1: After reset, every register reads zero (dwords 04h, 90h, 94h, 98h), and `inta`, `intx_sts` and `msi_valid` are low.
- R2: In dword 90h, bit 16 is the message-interrupt enable and bits 22:20 are the message-count grant. Both are written only when `cfg_be[2]` is set.
- R3: Bits 19:17 of dword 90h are the requested-count field and always read 000b, which means one message. Bits 31:23 and 15:0 of that dword also read zero, whatever is written.
- R4: The grant field stores and returns any 3-bit code. The codes are 000=1, 001=2, 010=4, 011=8, 100=16 and 101=32 messages, and 110 and 111 are reserved.
- R5: Dword 94h is the message address. Bits 31:2 are writable byte by byte under `cfg_be`, and bits 1:0 always read 00b.
- R6: Dword 98h bits 15:0 hold the message data and are writable per byte under `cfg_be[1:0]`. Bits 31:16 read zero.
- R7: With the enable at 1, an event on `pme_evt` raises `msi_valid` at the next clock edge, if no write is outstanding. `msi_addr` then equals the address register and `msi_data` equals the message data zero-extended to 32 bits.
- R8: With the enable at 1, an event neither sets `intx_sts` nor raises `inta`.
- R9: With the enable at 0, an event produces no memory write. It sets `intx_sts` (dword 04h bit 19) and raises `inta` at the next edge.
- R10: A write with `cfg_be[2]` set and data bit 19 at 1 to dword 04h clears the status flag and `inta`. A 0 in bit 19, or a cleared byte enable, leaves the flag unchanged. An event in the same cycle as the clear keeps the flag set.
- R11: While `msi_valid` is high and `msi_ready` is low, `msi_valid`, `msi_addr` and `msi_data` hold steady.
- R12: Events that arrive while a write is waiting merge into one pending request. That request is presented in the cycle after the handshake, with the address and data current at that moment. An event during a handshake cycle also yields exactly one further write.
- R13: Reads of any other dword return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr | input | 8 | Configuration byte offset; bits 1:0 ignored |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the addressed dword |
| pme_evt | input | 1 | One-cycle power-management event pulse |
| msi_valid | output | 1 | Memory-write request valid |
| msi_ready | input | 1 | Memory-write request accepted |
| msi_addr | output | 32 | Memory-write address |
| msi_data | output | 32 | Memory-write data |
| inta | output | 1 | Legacy interrupt level |
| intx_sts | output | 1 | Legacy interrupt status flag |

## Verification
Events are applied with the enable off, which must touch only the legacy flag. They are then applied with the enable on and the sink always ready, which checks delivery and the absence of any legacy side effect. Bursts of events arrive while the sink stalls, so merging can be told apart from dropping or duplicating. Back-to-back events land on a handshake edge, which separates a reload from a drop. Register patterns mix full and partial byte enables, which shows the masking on read-only bits, alignment bits and disabled bytes.

// File: rtl/msi_irq_dispatch.sv
module msi_irq_dispatch #(
  parameter logic [7:0] CAP_OFS = 8'h90,
  parameter logic [7:0] STS_OFS = 8'h04,
  parameter int         STS_BIT = 19
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  cfg_addr,
  input  logic [3:0]  cfg_be,
  input  logic        cfg_wr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        pme_evt,
  output logic        msi_valid,
  input  logic        msi_ready,
  output logic [31:0] msi_addr,
  output logic [31:0] msi_data,
  output logic        inta,
  output logic        intx_sts
);

  localparam logic [5:0] CTRL_DW  = CAP_OFS[7:2];
  localparam logic [5:0] ADDR_DW  = CAP_OFS[7:2] + 6'd1;
  localparam logic [5:0] DATA_DW  = CAP_OFS[7:2] + 6'd2;
  localparam logic [5:0] STS_DW   = STS_OFS[7:2];
  localparam int         STS_BYTE = STS_BIT / 8;
  localparam logic [2:0] REQ_CNT  = 3'b000;

  logic        msi_en;
  logic [2:0]  grant;
  logic [29:0] maddr;
  logic [15:0] mdata;
  logic        sts;
  logic        pend;

  wire [5:0] dw      = cfg_addr[7:2];
  wire       wr_ctrl = cfg_wr && (dw == CTRL_DW);
  wire       wr_addr = cfg_wr && (dw == ADDR_DW);
  wire       wr_data = cfg_wr && (dw == DATA_DW);
  wire       wr_sts  = cfg_wr && (dw == STS_DW);
  wire       fire    = pme_evt && msi_en;
  wire       hs      = msi_valid && msi_ready;
  wire [15:0] ctrl_word = {9'd0, grant, REQ_CNT, msi_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_en <= 1'b0;
      grant  <= 3'b000;
    end else if (wr_ctrl && cfg_be[2]) begin
      msi_en <= cfg_wdata[16];
      grant  <= cfg_wdata[22:20];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maddr <= '0;
    end else if (wr_addr) begin
      if (cfg_be[0]) maddr[5:0]   <= cfg_wdata[7:2];
      if (cfg_be[1]) maddr[13:6]  <= cfg_wdata[15:8];
      if (cfg_be[2]) maddr[21:14] <= cfg_wdata[23:16];
      if (cfg_be[3]) maddr[29:22] <= cfg_wdata[31:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdata <= '0;
    end else if (wr_data) begin
      if (cfg_be[0]) mdata[7:0]  <= cfg_wdata[7:0];
      if (cfg_be[1]) mdata[15:8] <= cfg_wdata[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sts <= 1'b0;
    else if (pme_evt && !msi_en)
      sts <= 1'b1;
    else if (wr_sts && cfg_be[STS_BYTE] && cfg_wdata[STS_BIT])
      sts <= 1'b0;
  end

  assign intx_sts = sts;
  assign inta     = sts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msi_valid <= 1'b0;
      pend      <= 1'b0;
      msi_addr  <= '0;
      msi_data  <= '0;
    end else if (!msi_valid) begin
      if (fire) begin
        msi_valid <= 1'b1;
        msi_addr  <= {maddr, 2'b00};
        msi_data  <= {16'd0, mdata};
      end
    end else if (hs) begin
      if (pend || fire) begin
        msi_addr <= {maddr, 2'b00};
        msi_data <= {16'd0, mdata};
        pend     <= 1'b0;
      end else begin
        msi_valid <= 1'b0;
      end
    end else if (fire) begin
      pend <= 1'b1;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (dw == CTRL_DW)      cfg_rdata = {ctrl_word, 16'd0};
    else if (dw == ADDR_DW) cfg_rdata = {maddr, 2'b00};
    else if (dw == DATA_DW) cfg_rdata = {16'd0, mdata};
    else if (dw == STS_DW)  cfg_rdata = 32'(sts) << STS_BIT;
  end

endmodule

// File: rtl/msi_irq_dispatch_chk.sv
module msi_irq_dispatch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic        pme_evt,
  input logic        msi_valid,
  input logic        msi_ready,
  input logic [31:0] msi_addr,
  input logic [31:0] msi_data,
  input logic        inta,
  input logic        intx_sts,
  input logic        msi_en,
  input logic        pend
);

  AST_MSI_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_evt && msi_en && !msi_valid) |=> msi_valid);                         // R7

  AST_NO_INTA_WITH_MSI: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_evt && msi_en && !inta) |=> !inta);                                   // R8

  AST_NO_MSI_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_valid && !pend && !msi_en) |=> !msi_valid);                          // R9

  AST_INTA_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_evt && !msi_en) |=> (inta && intx_sts));                              // R9

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_sts && !cfg_wr) |=> intx_sts);                                       // R10

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_addr) && $stable(msi_data))); // R11

  AST_PEND_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && msi_ready && pend) |=> msi_valid);                           // R12

endmodule

bind msi_irq_dispatch msi_irq_dispatch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .pme_evt(pme_evt),
  .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_addr(msi_addr),
  .msi_data(msi_data), .inta(inta), .intx_sts(intx_sts),
  .msi_en(msi_en), .pend(pend)
);

// File: tb/tb_msi_irq_dispatch.sv
`timescale 1ns/1ps
module tb_msi_irq_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        pme_evt = 1'b0;
  logic        msi_valid;
  logic        msi_ready = 1'b1;
  logic [31:0] msi_addr, msi_data;
  logic        inta, intx_sts;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [63:0] expq[$];
  bit prev_wait = 0;
  logic [63:0] prev_req;

  always #4 clk = ~clk;

  msi_irq_dispatch dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pme_evt(pme_evt), .msi_valid(msi_valid), .msi_ready(msi_ready),
    .msi_addr(msi_addr), .msi_data(msi_data), .inta(inta), .intx_sts(intx_sts)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(cfg_rdata === exp, tag, {32'd0, cfg_rdata}, {32'd0, exp});
  endtask

  task automatic event_pulse();
    @(negedge clk);
    pme_evt = 1'b1;
    @(negedge clk);
    pme_evt = 1'b0;
  endtask

  // monitor: scoreboard of delivered memory writes
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_wait) begin
        check(msi_valid && ({msi_addr, msi_data} === prev_req), "R11 request held while stalled",
              {msi_addr, msi_data}, prev_req);
      end
      prev_wait = msi_valid && !msi_ready;
      prev_req  = {msi_addr, msi_data};
      if (msi_valid && msi_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9/R12 unexpected memory write", {msi_addr, msi_data}, 64'd0);
        end else begin
          logic [63:0] e;
          e = expq.pop_front();
          check({msi_addr, msi_data} === e, "R7/R12 memory write contents", {msi_addr, msi_data}, e);
        end
      end
    end
  end

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cfg_check(8'h90, 32'h0, "R1 control reset");
    cfg_check(8'h94, 32'h0, "R1 address reset");
    cfg_check(8'h98, 32'h0, "R1 data reset");
    cfg_check(8'h04, 32'h0, "R1 status reset");
    check({inta, intx_sts, msi_valid} === 3'b000, "R1 outputs reset", {61'd0, inta, intx_sts, msi_valid}, 64'd0);

    // R2 R3 control word layout; requested-count field stays 000
    cfg_write(8'h90, 4'hF, 32'hFFFF_FFFF);
    cfg_check(8'h90, 32'h0071_0000, "R2 R3 control all-ones write");
    cfg_write(8'h90, 4'b1011, 32'h0000_0000);
    cfg_check(8'h90, 32'h0071_0000, "R2 byte2 disabled keeps control");
    // R4 grant codes, including reserved
    cfg_write(8'h90, 4'b0100, 32'h0050_0000);
    cfg_check(8'h90, 32'h0050_0000, "R4 grant 101 stored");
    cfg_write(8'h90, 4'b0100, 32'h0060_0000);
    cfg_check(8'h90, 32'h0060_0000, "R4 grant 110 stored");
    cfg_write(8'h90, 4'b0100, 32'h0000_0000);

    // R5 address register
    cfg_write(8'h94, 4'hF, 32'hFFFF_FFFF);
    cfg_check(8'h94, 32'hFFFF_FFFC, "R5 low bits read zero");
    cfg_write(8'h94, 4'b0001, 32'h0000_0000);
    cfg_check(8'h94, 32'hFFFF_FF00, "R5 single byte write");
    cfg_write(8'h94, 4'hF, 32'h1234_5677);
    cfg_check(8'h94, 32'h1234_5674, "R5 aligned value");

    // R6 message data
    cfg_write(8'h98, 4'hF, 32'hABCD_1234);
    cfg_check(8'h98, 32'h0000_1234, "R6 upper half zero");
    cfg_write(8'h98, 4'b0010, 32'h0000_5600);
    cfg_check(8'h98, 32'h0000_5634, "R6 byte1 only");

    // R13 unimplemented offsets
    cfg_write(8'h40, 4'hF, 32'hFFFF_FFFF);
    cfg_check(8'h40, 32'h0, "R13 unimplemented reads zero");
    cfg_check(8'h9C, 32'h0, "R13 offset after data reads zero");
    cfg_check(8'h94, 32'h1234_5674, "R13 stray write left address");

    // R9 legacy path with enable off
    event_pulse();
    #1;
    check(inta && intx_sts, "R9 event sets legacy flag", {62'd0, inta, intx_sts}, 64'd3);
    cfg_check(8'h04, 32'h0008_0000, "R9 status at bit 19");
    check(!msi_valid, "R9 no memory write", {63'd0, msi_valid}, 64'd0);
    // R10 clear rules
    cfg_write(8'h04, 4'b0100, 32'h0000_0000);
    cfg_check(8'h04, 32'h0008_0000, "R10 zero write keeps flag");
    cfg_write(8'h04, 4'b1011, 32'h0008_0000);
    cfg_check(8'h04, 32'h0008_0000, "R10 disabled byte keeps flag");
    cfg_write(8'h04, 4'b0100, 32'h0008_0000);
    #1;
    check(!inta && !intx_sts, "R10 write one clears", {62'd0, inta, intx_sts}, 64'd0);
    @(negedge clk);
    cfg_addr = 8'h04; cfg_be = 4'b0100; cfg_wdata = 32'h0008_0000; cfg_wr = 1'b1; pme_evt = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; pme_evt = 1'b0; cfg_be = '0;
    #1;
    check(intx_sts && inta, "R10 event wins over clear", {62'd0, inta, intx_sts}, 64'd3);
    cfg_write(8'h04, 4'b0100, 32'h0008_0000);

    // R7 R8 message path, sink ready
    cfg_write(8'h90, 4'b0100, 32'h0001_0000);
    expq.push_back({32'h1234_5674, 32'h0000_5634});
    event_pulse();
    #1;
    check(msi_valid, "R7 valid after event", {63'd0, msi_valid}, 64'd1);
    check(!inta && !intx_sts, "R8 no legacy effect", {62'd0, inta, intx_sts}, 64'd0);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R7 write delivered", expq.size(), 64'd0);

    // R11 R12 stalled sink with a burst of events
    msi_ready = 1'b0;
    expq.push_back({32'h1234_5674, 32'h0000_5634});
    event_pulse();
    cfg_write(8'h94, 4'hF, 32'hCAFE_0010);
    event_pulse();
    event_pulse();
    event_pulse();
    repeat (3) @(negedge clk);
    #1;
    check(msi_valid && msi_addr == 32'h1234_5674, "R11 address held", {32'd0, msi_addr}, 64'h1234_5674);
    expq.push_back({32'hCAFE_0010, 32'h0000_5634});
    @(negedge clk);
    msi_ready = 1'b1;
    repeat (6) @(negedge clk);
    check(expq.size() == 0 && !msi_valid, "R12 burst merged to one", expq.size(), 64'd0);

    // R12 event during a handshake edge
    expq.push_back({32'hCAFE_0010, 32'h0000_5634});
    expq.push_back({32'hCAFE_0010, 32'h0000_5634});
    @(negedge clk);
    pme_evt = 1'b1;
    @(negedge clk);
    @(negedge clk);
    pme_evt = 1'b0;
    repeat (6) @(negedge clk);
    check(expq.size() == 0 && !msi_valid, "R12 handshake event reloads once", expq.size(), 64'd0);
    check(!inta, "R8 legacy line idle", {63'd0, inta}, 64'd0);

    // R9 enable off again: no further memory write
    cfg_write(8'h90, 4'b0100, 32'h0000_0000);
    event_pulse();
    repeat (3) @(negedge clk);
    check(!msi_valid && inta, "R9 disabled path stays legacy", {62'd0, msi_valid, inta}, 64'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule